// File: doc/BRIEF.md
# Calibrated Temperature Converter with Group Maximum

This block turns raw thermal sensor samples into signed temperatures in millidegrees Celsius and reduces a group of such samples to a single hottest value. Per-chip trim constants are taken from three 32-bit fuse words: an ADC gain term, an offset slope, a calibration temperature, and one reference code for each of five sensing points. When the fuse words are marked as not programmed, fixed default constants are used in their place.

Samples arrive one at a time as a sensor code plus a raw code, with flags that mark the first and the last sample of a group. A single shared restoring divider runs two truncating divisions for each sample. A fixed-point scale step then applies the reference and the calibration temperature. Readings above the plausibility limit are forced to zero. The running maximum is reported with a one-cycle done pulse after the sample flagged as last. The block accepts a sample only while it is idle. Its busy output tells the producer when to hold off.

Top module: `tconv_max`

## Requirements
- R1: After reset, `busy` and `done` are low and `max_out` is 0.
- R2: When fuse word 0 bit 0 is 1, the constants are decoded as follows. From word 0: slope = bits [31:26], ref0 = [25:17], ref1 = [16:8], cal_deg = [6:1]. From word 1: gain = bits [31:22], ref2 = [8:0]. From word 2: ref3 = [31:23], ref4 = [22:14].
- R3: When fuse word 0 bit 0 is 0, the constants are gain 512, cal_deg 40, slope 0 and 260 for every reference, whatever the other fuse bits hold.
- R4: Only the low 12 bits of `in_raw` take part in the conversion.
- R5: Each sample is converted in signed 32-bit arithmetic. First k = (1627604160 / (165 + slope)) / (10000 + gain), with both divisions truncating. Then t = (k × (raw − ref − 3350)) >>> 3. The converted value is cal_deg × 500 − t.
- R6: A converted value greater than 200000 is replaced by 0 before it joins the maximum.
- R7: A sample with `in_start` set seeds the running maximum with the most negative 32-bit value before it is included. Other samples are compared against the maximum so far. A single negative value in a group is reported unchanged.
- R8: Sensor codes 0 to 4 select ref0 to ref4. Codes 5 to 7 use the reference value 260.
- R9: A sample is taken when `in_valid` is high and `busy` is low. `busy` is high in the cycle after acceptance. Any `in_valid` seen while `busy` is high is ignored and produces no `done`.
- R10: After a sample flagged with `in_last`, `done` is high for exactly one cycle and `max_out` carries the group maximum. `max_out` changes only together with `done`, and `busy` is low while `done` is high.
- R11: `done` rises on the 66th rising clock edge after the accepting edge (2 × 32 + 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_w0 | input | 32 | Fuse word 0: valid flag, slope, ref0, ref1, cal_deg |
| fuse_w1 | input | 32 | Fuse word 1: gain, ref2 |
| fuse_w2 | input | 32 | Fuse word 2: ref3, ref4 |
| in_valid | input | 1 | Sample present |
| in_start | input | 1 | First sample of a group |
| in_last | input | 1 | Last sample of a group |
| in_sensor | input | 3 | Sensor code |
| in_raw | input | 16 | Raw ADC code (low 12 bits used) |
| busy | output | 1 | Conversion in progress; new samples ignored |
| done | output | 1 | One-cycle pulse: group maximum valid |
| max_out | output | 32 | Signed group maximum in millidegrees Celsius |

## Verification
Faults inside the block show up at the ports in different ways. A wrong divider quotient or a bad fuse field shifts every converted value, and the error appears in `max_out` at the very next `done`, 66 cycles after the sample is accepted. A running maximum that is not reseeded, or one that picks up an ignored sample, stays hidden until the group's `done`, where the reported maximum differs from the independently computed one. A control state that hangs shows as a missing `done`, and a state that slips shows as a `done` that comes at a different edge count.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

    localparam int RAW_W   = 12;
    localparam int IN_W    = 16;
    localparam int REF_W   = 9;
    localparam int NUM_REF = 5;
    localparam int GAIN_W  = 10;
    localparam int CALI_W  = 6;
    localparam int SLOPE_W = 6;
    localparam int SEL_W   = 3;
    localparam int DATA_W  = 32;
    localparam int DIV_DW  = 32;
    localparam int FUSE_W  = 32;

    // numerator of the first division: 203450520 scaled by 8
    localparam logic [DIV_DW-1:0] SCALED_NUM = 32'd1627604160;
    localparam int SLOPE_BASE = 165;
    localparam int GAIN_BASE  = 10000;
    localparam int RAW_OFFSET = 3350;
    localparam int DEG_MULT   = 500;
    localparam int FRAC_SH    = 3;
    localparam int CLAMP_LIM  = 200000;

    localparam int DEF_GAIN  = 512;
    localparam int DEF_REF   = 260;
    localparam int DEF_CALI  = 40;
    localparam int DEF_SLOPE = 0;

    localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [GAIN_W-1:0]               gain;
        logic [CALI_W-1:0]               cali;
        logic [SLOPE_W-1:0]              slope;
        logic [NUM_REF-1:0][REF_W-1:0]   refs;
    } cal_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DIV1 = 2'd1,
        S_DIV2 = 2'd2
    } state_t;

    function automatic logic signed [DATA_W-1:0] smax(
        input logic signed [DATA_W-1:0] a,
        input logic signed [DATA_W-1:0] b
    );
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tconv_fuse_decode.sv
module tconv_fuse_decode
    import tconv_pkg::*;
(
    input  logic [FUSE_W-1:0] w0,
    input  logic [FUSE_W-1:0] w1,
    input  logic [FUSE_W-1:0] w2,
    output cal_t              cal
);

    cal_t fused;
    cal_t dflt;
    logic unused_bits;

    assign unused_bits = ^{w0[7], w1[21:9], w2[13:0]};

    always_comb begin
        fused.slope   = w0[31:26];
        fused.refs[0] = w0[25:17];
        fused.refs[1] = w0[16:8];
        fused.cali    = w0[6:1];
        fused.gain    = w1[31:22];
        fused.refs[2] = w1[8:0];
        fused.refs[3] = w2[31:23];
        fused.refs[4] = w2[22:14];

        dflt.gain  = GAIN_W'(DEF_GAIN);
        dflt.cali  = CALI_W'(DEF_CALI);
        dflt.slope = SLOPE_W'(DEF_SLOPE);
        for (int i = 0; i < NUM_REF; i++) begin
            dflt.refs[i] = REF_W'(DEF_REF);
        end

        cal = w0[0] ? fused : dflt;
    end

endmodule

// File: rtl/tconv_divider.sv
module tconv_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         fin
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;

    always_comb trial = {rem, quo[W-1]} - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            quo   <= '0;
            den_q <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem   <= '0;
                quo   <= num;
                den_q <= den;
                cnt   <= CW'(W);
                run   <= 1'b1;
            end else if (run) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= {rem[W-2:0], quo[W-1]};
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tconv_scale.sv
module tconv_scale
    import tconv_pkg::*;
(
    input  logic signed [DATA_W-1:0] coef,
    input  logic [RAW_W-1:0]         raw,
    input  logic [REF_W-1:0]         refv,
    input  logic [CALI_W-1:0]        cali,
    output logic signed [DATA_W-1:0] result
);

    logic signed [DATA_W-1:0] diff;
    logic signed [DATA_W-1:0] prod;
    logic signed [DATA_W-1:0] shifted;
    logic signed [DATA_W-1:0] base;
    logic signed [DATA_W-1:0] res;

    always_comb begin
        diff    = $signed({{(DATA_W-RAW_W){1'b0}}, raw})
                - $signed({{(DATA_W-REF_W){1'b0}}, refv})
                - DATA_W'(RAW_OFFSET);
        prod    = coef * diff;
        shifted = prod >>> FRAC_SH;
        base    = $signed({{(DATA_W-CALI_W){1'b0}}, cali}) * DATA_W'(DEG_MULT);
        res     = base - shifted;
        result  = (res > DATA_W'(CLAMP_LIM)) ? '0 : res;
    end

endmodule

// File: rtl/tconv_max.sv
module tconv_max
    import tconv_pkg::*;
#(
    parameter int DIV_W = DIV_DW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [FUSE_W-1:0]        fuse_w0,
    input  logic [FUSE_W-1:0]        fuse_w1,
    input  logic [FUSE_W-1:0]        fuse_w2,
    input  logic                     in_valid,
    input  logic                     in_start,
    input  logic                     in_last,
    input  logic [SEL_W-1:0]         in_sensor,
    input  logic [IN_W-1:0]          in_raw,
    output logic                     busy,
    output logic                     done,
    output logic signed [DATA_W-1:0] max_out
);

    cal_t                     cal_now;
    cal_t                     cal_q;
    state_t                   st;
    logic [RAW_W-1:0]         raw_q;
    logic [REF_W-1:0]         ref_q;
    logic [REF_W-1:0]         ref_sel;
    logic                     start_q;
    logic                     last_q;
    logic signed [DATA_W-1:0] acc;
    logic signed [DATA_W-1:0] conv;
    logic signed [DATA_W-1:0] seed;
    logic signed [DATA_W-1:0] best;
    logic                     accept;
    logic                     div_go;
    logic                     div_fin;
    logic [DIV_W-1:0]         div_num;
    logic [DIV_W-1:0]         div_den;
    logic [DIV_W-1:0]         div_quo;
    logic                     unused_raw;

    assign unused_raw = ^in_raw[IN_W-1:RAW_W];

    tconv_fuse_decode u_dec (
        .w0  (fuse_w0),
        .w1  (fuse_w1),
        .w2  (fuse_w2),
        .cal (cal_now)
    );

    always_comb begin
        ref_sel = REF_W'(DEF_REF);
        for (int i = 0; i < NUM_REF; i++) begin
            if (in_sensor == SEL_W'(i)) ref_sel = cal_now.refs[i];
        end
    end

    assign accept  = (st == S_IDLE) && in_valid;
    assign div_go  = accept || ((st == S_DIV1) && div_fin);
    assign div_num = accept ? DIV_W'(SCALED_NUM) : div_quo;
    assign div_den = accept ? DIV_W'(SLOPE_BASE) + DIV_W'(cal_now.slope)
                            : DIV_W'(GAIN_BASE) + DIV_W'(cal_q.gain);

    tconv_divider #(.W(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (div_num),
        .den (div_den),
        .quo (div_quo),
        .fin (div_fin)
    );

    tconv_scale u_scale (
        .coef   ($signed(DATA_W'(div_quo))),
        .raw    (raw_q),
        .refv   (ref_q),
        .cali   (cal_q.cali),
        .result (conv)
    );

    assign seed = start_q ? MOST_NEG : acc;
    assign best = smax(seed, conv);
    assign busy = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cal_q   <= '0;
            raw_q   <= '0;
            ref_q   <= '0;
            start_q <= 1'b0;
            last_q  <= 1'b0;
            acc     <= MOST_NEG;
            done    <= 1'b0;
            max_out <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (in_valid) begin
                        cal_q   <= cal_now;
                        raw_q   <= in_raw[RAW_W-1:0];
                        ref_q   <= ref_sel;
                        start_q <= in_start;
                        last_q  <= in_last;
                        st      <= S_DIV1;
                    end
                end
                S_DIV1: begin
                    if (div_fin) st <= S_DIV2;
                end
                S_DIV2: begin
                    if (div_fin) begin
                        acc <= best;
                        if (last_q) begin
                            done    <= 1'b1;
                            max_out <= best;
                        end
                        st <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tconv_max_chk.sv
module tconv_max_chk
    import tconv_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     busy,
    input logic                     done,
    input logic signed [DATA_W-1:0] max_out
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(max_out));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    clamp_limit_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (max_out <= DATA_W'(CLAMP_LIM)));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |=> busy);

endmodule

bind tconv_max tconv_max_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .busy     (busy),
    .done     (done),
    .max_out  (max_out)
);

// File: tb/tconv_max_tb.sv
module tconv_max_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EDGE_LAT   = 2 * 32 + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fuse_w0 = '0;
    logic [31:0] fuse_w1 = '0;
    logic [31:0] fuse_w2 = '0;
    logic        in_valid = 1'b0;
    logic        in_start = 1'b0;
    logic        in_last = 1'b0;
    logic [2:0]  in_sensor = '0;
    logic [15:0] in_raw = '0;
    logic        busy;
    logic        done;
    logic signed [31:0] max_out;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tconv_max u_dut (
        .clk(clk), .rst(rst),
        .fuse_w0(fuse_w0), .fuse_w1(fuse_w1), .fuse_w2(fuse_w2),
        .in_valid(in_valid), .in_start(in_start), .in_last(in_last),
        .in_sensor(in_sensor), .in_raw(in_raw),
        .busy(busy), .done(done), .max_out(max_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model built from R2..R8
    function automatic int model(input logic [31:0] w0, input logic [31:0] w1,
                                 input logic [31:0] w2, input int sensor, input int raw16);
        int gain, cali, slope, rf, raw, t, res;
        int refs[5];
        raw = raw16 & 32'hfff;                       // R4
        if (w0[0]) begin                             // R2
            slope = int'(w0[31:26]); cali = int'(w0[6:1]);
            gain = int'(w1[31:22]);
            refs[0] = int'(w0[25:17]); refs[1] = int'(w0[16:8]);
            refs[2] = int'(w1[8:0]);
            refs[3] = int'(w2[31:23]); refs[4] = int'(w2[22:14]);
        end else begin                               // R3
            slope = 0; cali = 40; gain = 512;
            for (int i = 0; i < 5; i++) refs[i] = 260;
        end
        rf = (sensor < 5) ? refs[sensor] : 260;      // R8
        t = 1627604160;                              // R5
        t = t / (165 + slope);
        t = t / (10000 + gain);
        t = t * (raw - rf - 3350);
        t = t >>> 3;
        res = cali * 500 - t;
        if (res > 200000) res = 0;                   // R6
        return res;
    endfunction

    task automatic send(input int sensor, input int raw, input bit st, input bit lst,
                        output int lat, output int val);
        @(negedge clk);
        in_valid = 1'b1; in_start = st; in_last = lst;
        in_sensor = 3'(sensor); in_raw = 16'(raw);
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
        lat = 1;
        val = 0;
        if (lst) begin
            while (!done && lat < 400) begin
                @(negedge clk);
                lat++;
            end
            val = max_out;
        end else begin
            while (busy && lat < 400) begin
                @(negedge clk);
                lat++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] cw0[4], cw1[4], cw2[4];
        int raws[6];
        int lat, val, exp, ndone;
        string tag;

        // cfg0: not programmed, garbage elsewhere (R3)
        cw0[0] = 32'hFFFF_FFFE; cw1[0] = 32'h1234_5678; cw2[0] = 32'h9ABC_DEF0;
        // cfg1: extremes slope 63, gain 1023, ref0 511, ref1 0, cali 63
        cw0[1] = (32'd63 << 26) | (32'd511 << 17) | (32'd0 << 8) | (32'd63 << 1) | 32'd1;
        cw1[1] = (32'd1023 << 22) | 32'd5;
        cw2[1] = (32'd400 << 23) | (32'd1 << 14);
        // cfg2: mid values
        cw0[2] = (32'd10 << 26) | (32'd300 << 17) | (32'd250 << 8) | (32'd45 << 1) | 32'd1;
        cw1[2] = (32'd700 << 22) | 32'd200;
        cw2[2] = (32'd123 << 23) | (32'd345 << 14);
        // cfg3: programmed all-zero fields
        cw0[3] = 32'd1; cw1[3] = 32'd0; cw2[3] = 32'd0;

        raws = '{0, 1, 1800, 3610, 4095, 16'hABCD};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 max_out", max_out, 0);

        // R11 latency on one sample
        fuse_w0 = cw0[0]; fuse_w1 = cw1[0]; fuse_w2 = cw2[0];
        send(0, 2000, 1'b1, 1'b1, lat, val);
        chk("R11 edges to done", lat - 1, EDGE_LAT);

        // sweep: single-sample groups, every sensor code, several raws and fuses
        for (int c = 0; c < 4; c++) begin
            fuse_w0 = cw0[c]; fuse_w1 = cw1[c]; fuse_w2 = cw2[c];
            for (int r = 0; r < 6; r++) begin
                for (int s = 0; s < 8; s++) begin
                    exp = model(cw0[c], cw1[c], cw2[c], s, raws[r]);
                    if (s > 4) tag = "R8 sensor code";
                    else if (raws[r] > 4095) tag = "R4 raw mask";
                    else if (exp == 0) tag = "R6 clamp";
                    else if (exp < 0) tag = "R7 negative single";
                    else if (cw0[c][0]) tag = "R2 fuse decode";
                    else tag = "R3 defaults";
                    send(s, raws[r], 1'b1, 1'b1, lat, val);
                    chk(tag, val, exp);
                end
            end
        end

        // R5 R7 multi-sample group
        fuse_w0 = cw0[2]; fuse_w1 = cw1[2]; fuse_w2 = cw2[2];
        begin
            int gr[5];
            int m;
            gr = '{3000, 3500, 3900, 2500, 4095};
            m = 32'h8000_0000;
            for (int i = 0; i < 5; i++) begin
                exp = model(cw0[2], cw1[2], cw2[2], i, gr[i]);
                if (exp > m) m = exp;
                send(i, gr[i], i == 0, i == 4, lat, val);
            end
            chk("R7 group max", val, m);
        end

        // R7 start reseeds: lower group after a higher one
        send(0, 4095, 1'b1, 1'b0, lat, val);
        send(1, 4000, 1'b0, 1'b1, lat, val);
        exp = model(cw0[2], cw1[2], cw2[2], 0, 4095);
        if (model(cw0[2], cw1[2], cw2[2], 1, 4000) > exp)
            exp = model(cw0[2], cw1[2], cw2[2], 1, 4000);
        chk("R7 reseed", val, exp);

        // R6 all-bogus group
        send(0, 0, 1'b1, 1'b0, lat, val);
        send(1, 1, 1'b0, 1'b1, lat, val);
        chk("R6 bogus group", val, 0);

        // R9 samples while busy are ignored
        fuse_w0 = cw0[0]; fuse_w1 = cw1[0]; fuse_w2 = cw2[0];
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1; in_sensor = 3'd0; in_raw = 16'd4095;
        @(negedge clk);
        chk("R9 busy after accept", int'(busy), 1);
        in_raw = 16'd0; in_sensor = 3'd2;
        repeat (3) @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 ignored sample", max_out, model(cw0[0], cw1[0], cw2[0], 0, 4095));
        @(negedge clk);
        chk("R10 done one cycle", int'(done), 0);
        ndone = 0;
        repeat (100) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk("R9 no extra done", ndone, 0);
        chk("R10 max_out held", max_out, model(cw0[0], cw1[0], cw2[0], 0, 4095));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule